// File: doc/BRIEF.md
# Auto-Conversion Rate Scheduler

This block decides when a temperature monitor's converter begins a conversion cycle. After reset it runs on its own: it issues a conversion as soon as the supply is usable, then repeats at an interval chosen by a three-bit rate code. The code runs from one conversion every 16 seconds (code 0) to 8 per second (code 7), and the interval halves at each step. A stop input suspends the automatic repeats. A one-shot input asks for a single conversion. A sticky valid flag shows when the first complete set of results exists.

Time is measured in base ticks of 62.5 ms produced by a prescaler, so code `c` gives an interval of `2^(8-c)` ticks. The prescaler length is a parameter, so the same logic can run with very short ticks. The converter is reached through a one-cycle start pulse and a busy input. The block never issues a start while a conversion is in progress. When the programmed interval is shorter than a conversion, the next conversion follows the previous one directly.

Top module: `conv_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `start_conv` and `data_valid` are low. The rate code resets to 2, and a power-up conversion request is pending.
- R2: `start_conv` is never asserted while `supply_ok` is low. A pending power-up request starts a conversion at the first clock edge that samples `supply_ok` high.
- R3: `data_valid` stays low until the first conversion ends. It goes high at the edge that first samples `adc_busy` low after a start, and it then stays high until reset.
- R4: With the reset rate code (2), auto-mode starts are 64 base ticks apart.
- R5: Rate code `c` (0..7, taken from `rate_wdata[2:0]`) gives an interval of `2^(8-c)` base ticks between successive auto-mode starts, when a conversion is shorter than that interval.
- R6: `start_conv` is a single-cycle pulse and is never issued while `adc_busy` is high. When the interval has already expired, the next start comes at the first edge after the edge that samples `adc_busy` low.
- R7: `rate_wdata[7:3]` has no effect on timing.
- R8: A rate write restarts the interval. If the write arrives while idle, the next auto start comes exactly one new interval after the write edge. If it arrives during a conversion, the interval counts from the edge that samples `adc_busy` low.
- R9: While `stop_req` is high, no automatic starts occur. A conversion already in progress runs to its end.
- R10: A falling edge of `stop_req` starts a conversion at the next clock edge, provided the block is idle and `supply_ok` is high.
- R11: A one-shot pulse while stopped and idle starts exactly one conversion, at the next edge.
- R12: A one-shot pulse while a conversion is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_we | input | 1 | Write strobe for the rate register |
| rate_wdata | input | 8 | Rate write data; only bits [2:0] are decoded |
| stop_req | input | 1 | High suspends automatic conversions |
| oneshot | input | 1 | Single-conversion request pulse |
| supply_ok | input | 1 | Supply above the converter lockout threshold |
| adc_busy | input | 1 | Converter is running a conversion |
| start_conv | output | 1 | One-cycle conversion start pulse |
| data_valid | output | 1 | Sticky flag: a full set of results exists |

## Verification
The bench builds the block with `TICK_CYC=4` and `SLOW_EXP=8`, so a base tick is 4 clocks. The slowest code then gives 1024 clocks between starts and the fastest gives 8. This makes it practical to sweep all eight codes, each with different garbage in the upper data bits. A modelled converter runs 20 busy cycles, so codes 6 and 7 reach the back-to-back regime and codes 0 to 5 stay interval-limited. The short ticks also let the bench time rate writes both during and between conversions, down to the exact clock edge.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_CONV = 2'd2
    } sched_st_e;

endpackage

// File: rtl/conv_sched_presc.sv
module conv_sched_presc #(
    parameter int TICK_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int PW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    // A clear loads 1, so a full tick period is counted from the clear edge.
    always_comb begin
        if (clr)       cnt_d = PW'(1);
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/conv_sched_rate.sv
module conv_sched_rate #(
    parameter int RATE_BITS = 3,
    parameter int SLOW_EXP  = 8,
    localparam int TW       = SLOW_EXP + 1,
    localparam int NCODES   = 1 << RATE_BITS
) (
    input  logic [RATE_BITS-1:0] code,
    output logic [TW-1:0]        period
);
    logic [TW-1:0] lut [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_lut
        assign lut[g] = TW'(1) << (SLOW_EXP - g);
    end

    assign period = lut[code];
endmodule

// File: rtl/conv_sched.sv
module conv_sched
    import conv_sched_pkg::*;
#(
    parameter int TICK_CYC   = 3125000,
    parameter int SLOW_EXP   = 8,
    parameter int RATE_BITS  = 3,
    parameter int DATA_W     = 8,
    parameter int RESET_CODE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_we,
    input  logic [DATA_W-1:0] rate_wdata,
    input  logic              stop_req,
    input  logic              oneshot,
    input  logic              supply_ok,
    input  logic              adc_busy,
    output logic              start_conv,
    output logic              data_valid
);
    localparam int TW = SLOW_EXP + 1;
    localparam logic [TW-1:0] TICK_SAT = TW'(1) << SLOW_EXP;

    typedef struct packed {
        sched_st_e            st;
        logic [RATE_BITS-1:0] code;
        logic [TW-1:0]        ticks;
        logic                 kick;
        logic                 hold;
        logic                 stop_prev;
        logic                 start;
        logic                 valid;
    } regs_t;

    localparam regs_t RST_VAL = '{
        st:        ST_IDLE,
        code:      RATE_BITS'(RESET_CODE),
        ticks:     '0,
        kick:      1'b1,
        hold:      1'b0,
        stop_prev: 1'b0,
        start:     1'b0,
        valid:     1'b0
    };

    regs_t r_d, r_q;

    logic          tick;
    logic          presc_clr;
    logic [TW-1:0] period;
    logic          run_edge;
    logic          due;
    logic          fire;
    logic          unused_hi;

    assign unused_hi = ^rate_wdata[DATA_W-1:RATE_BITS];

    conv_sched_presc #(
        .TICK_CYC(TICK_CYC)
    ) u_presc (
        .clk (clk),
        .rst (rst),
        .clr (presc_clr),
        .tick(tick)
    );

    conv_sched_rate #(
        .RATE_BITS(RATE_BITS),
        .SLOW_EXP (SLOW_EXP)
    ) u_rate (
        .code  (r_q.code),
        .period(period)
    );

    always_comb begin
        r_d           = r_q;
        r_d.start     = 1'b0;
        r_d.stop_prev = stop_req;
        presc_clr     = 1'b0;
        fire          = 1'b0;
        run_edge      = r_q.stop_prev && !stop_req;
        due           = !r_q.hold && (r_q.ticks >= period);

        // Pending run requests are remembered until they can be served.
        if (run_edge) r_d.kick = 1'b1;
        if (stop_req) r_d.kick = 1'b0;

        // Base-tick count since the last start, saturating at the slowest interval.
        if (tick && (r_q.ticks < TICK_SAT)) r_d.ticks = r_q.ticks + TW'(1);

        unique case (r_q.st)
            ST_IDLE: begin
                r_d.hold = 1'b0;
                if (supply_ok) begin
                    if (oneshot) fire = 1'b1;
                    else if (!stop_req && (r_q.kick || run_edge || due)) fire = 1'b1;
                end
            end
            ST_ARM: begin
                if (adc_busy) r_d.st = ST_CONV;
            end
            ST_CONV: begin
                if (!adc_busy) begin
                    r_d.st    = ST_IDLE;
                    r_d.valid = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (fire) begin
            r_d.st    = ST_ARM;
            r_d.start = 1'b1;
            r_d.kick  = 1'b0;
            r_d.ticks = '0;
            presc_clr = 1'b1;
        end

        // A rate write restarts the interval; the count stays frozen until idle.
        if (rate_we) begin
            r_d.code  = rate_wdata[RATE_BITS-1:0];
            r_d.hold  = 1'b1;
            r_d.ticks = '0;
            presc_clr = 1'b1;
        end else if (r_q.hold && (r_q.st != ST_IDLE)) begin
            r_d.ticks = '0;
            presc_clr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= RST_VAL;
        else     r_q <= r_d;
    end

    assign start_conv = r_q.start;
    assign data_valid = r_q.valid;
endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk (
    input logic clk,
    input logic rst,
    input logic stop_req,
    input logic oneshot,
    input logic supply_ok,
    input logic adc_busy,
    input logic start_conv,
    input logic data_valid
);
    // R2
    start_needs_supply_chk: assert property (@(posedge clk) disable iff (rst)
        start_conv |-> $past(supply_ok));

    // R6
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_conv |-> !$past(adc_busy));

    // R6
    start_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_conv |=> !start_conv);

    // R3
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> data_valid);

    // R9
    stopped_start_needs_oneshot_chk: assert property (@(posedge clk) disable iff (rst)
        (start_conv && $past(stop_req)) |-> $past(oneshot));
endmodule

bind conv_sched conv_sched_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .stop_req  (stop_req),
    .oneshot   (oneshot),
    .supply_ok (supply_ok),
    .adc_busy  (adc_busy),
    .start_conv(start_conv),
    .data_valid(data_valid)
);

// File: tb/sim_conv_sched.sv
module sim_conv_sched;
    localparam int T    = 4;
    localparam int SEXP = 8;
    localparam int CONV = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rate_we = 1'b0;
    logic [7:0] rate_wdata = '0;
    logic       stop_req = 1'b0;
    logic       oneshot = 1'b0;
    logic       supply_ok = 1'b0;
    logic       adc_busy;
    logic       start_conv;
    logic       data_valid;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int nstart = 0;
    int last_start = 0;
    int prev_start = 0;
    int valid_cyc = -1;
    int bcnt = 0;

    conv_sched #(
        .TICK_CYC(T),
        .SLOW_EXP(SEXP)
    ) u0 (
        .clk(clk), .rst(rst), .rate_we(rate_we), .rate_wdata(rate_wdata),
        .stop_req(stop_req), .oneshot(oneshot), .supply_ok(supply_ok),
        .adc_busy(adc_busy), .start_conv(start_conv), .data_valid(data_valid)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Converter model and output monitor, acting on falling edges.
    initial begin
        adc_busy = 1'b0;
        forever begin
            @(negedge clk);
            if (bcnt > 0) begin
                bcnt--;
                if (bcnt == 0) adc_busy = 1'b0;
            end
            if (start_conv) begin
                nstart++;
                prev_start = last_start;
                last_start = cyc;
                adc_busy   = 1'b1;
                bcnt       = CONV;
            end
            if (data_valid && valid_cyc < 0) valid_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_starts(input int n);
        int target = nstart + n;
        for (int i = 0; i < 5000 && nstart < target; i++) step(1);
    endtask

    task automatic write_rate(input logic [7:0] v);
        rate_wdata = v;
        rate_we    = 1'b1;
        step(1);
        rate_we    = 1'b0;
    endtask

    function automatic int expect_gap(input int c);
        int p = T << (SEXP - c);
        return (p > CONV + 2) ? p : CONV + 2;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s, e, n0, w;
        step(4);
        // R1: outputs during reset
        check(start_conv == 1'b0 && data_valid == 1'b0, "R1", {start_conv, data_valid}, 0);
        rst = 1'b0;
        step(1);
        // R1: first cycle out of reset
        check(start_conv == 1'b0 && data_valid == 1'b0, "R1", {start_conv, data_valid}, 0);

        // R2: supply gate holds off the power-up conversion
        step(60);
        check(nstart == 0, "R2", nstart, 0);
        s = cyc;
        supply_ok = 1'b1;
        wait_starts(1);
        check(last_start == s + 1, "R2", last_start, s + 1);

        // R3: valid flag rises when the first conversion ends
        step(CONV + 5);
        check(valid_cyc == last_start + CONV + 1, "R3", valid_cyc, last_start + CONV + 1);

        // R4: reset rate code 2
        wait_starts(1);
        check(last_start - prev_start == expect_gap(2), "R4", last_start - prev_start, expect_gap(2));

        // R5 / R6 / R7: sweep every code with junk in the upper bits
        for (int c = 0; c < 8; c++) begin
            write_rate({5'(c * 5 + 3), 3'(c)});
            wait_starts(2);
            if (c >= 6)
                check(last_start - prev_start == expect_gap(c), "R6", last_start - prev_start, expect_gap(c));
            else
                check(last_start - prev_start == expect_gap(c), "R5", last_start - prev_start, expect_gap(c));
        end
        // R7: upper bits ignored
        write_rate(8'hFD);
        wait_starts(2);
        check(last_start - prev_start == 32, "R7", last_start - prev_start, 32);

        // R8: write during a conversion counts from the end of that conversion
        write_rate(8'h03);
        wait_starts(2);
        e = last_start;
        step(5);
        write_rate(8'h04);
        wait_starts(1);
        check(last_start == e + CONV + 1 + 64, "R8", last_start, e + CONV + 1 + 64);
        // R8: write while idle counts from the write edge
        step(CONV + 5);
        w = cyc;
        write_rate(8'h04);
        wait_starts(1);
        check(last_start == w + 1 + 64, "R8", last_start, w + 1 + 64);

        // R2: supply loss in auto mode blocks starts
        step(CONV + 5);
        supply_ok = 1'b0;
        n0 = nstart;
        step(600);
        check(nstart == n0, "R2", nstart, n0);
        supply_ok = 1'b1;
        wait_starts(1);
        check(nstart == n0 + 1, "R2", nstart, n0 + 1);

        // R9: stop during a conversion lets it finish, then no more starts
        wait_starts(1);
        step(3);
        stop_req = 1'b1;
        n0 = nstart;
        step(CONV + 3);
        check(adc_busy == 1'b0, "R9", adc_busy, 0);
        step(600);
        check(nstart == n0, "R9", nstart, n0);

        // R10: clearing stop starts a conversion at once
        s = cyc;
        stop_req = 1'b0;
        wait_starts(1);
        check(last_start == s + 1, "R10", last_start, s + 1);
        step(1);
        stop_req = 1'b1;
        step(CONV + 5);

        // R11: one-shot while stopped gives exactly one conversion
        n0 = nstart;
        s = cyc;
        oneshot = 1'b1;
        step(1);
        oneshot = 1'b0;
        step(400);
        check(last_start == s + 1, "R11", last_start, s + 1);
        check(nstart == n0 + 1, "R11", nstart, n0 + 1);

        // R12: one-shot during a conversion is ignored
        n0 = nstart;
        oneshot = 1'b1;
        step(1);
        oneshot = 1'b0;
        step(5);
        oneshot = 1'b1;
        step(1);
        oneshot = 1'b0;
        step(400);
        check(nstart == n0 + 1, "R12", nstart, n0 + 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule